// File: doc/BRIEF.md
# Raster Timing Parameter Generator

The block takes a display mode and turns it into two things. The mode is given per axis as sync length, back porch, active length and front porch, with a bits-per-pixel value beside it. The first is the set of derived raster values that an output head is programmed with: total, sync end, blank end and blank start for each axis, plus a pixel-depth select. The second is a pair of free-running counters, horizontal and vertical, that turn those values into active-low sync, blank flags and a data-enable window.

The derived values form a chain. Sync end is the sync length less one. Blank end adds the back porch to sync end. Blank start adds the active length to blank end. The counters use zero-based positions and compare against these values rather than against the porch counts. The mode inputs are sampled only at the end of a frame, so a frame already under way is never torn by a change. A mode with a zero sync length or a zero active length on either axis is marked unusable, and it holds the counters at the origin with every output idle. Only progressive scan is produced.

Top module: `raster_timing_gen`

## Requirements
- R1: `h_total` and `v_total` each equal the sum of that axis's sync length, back porch, active length and front porch.
- R2: `h_sync_end` and `v_sync_end` each equal that axis's sync length minus one.
- R3: Each blank-end output equals that axis's sync end plus its back porch.
- R4: Each blank-start output equals that axis's blank end plus its active length.
- R5: With a usable mode, `h_pos` counts 0 to `h_total`-1 and then returns to 0. `v_pos` advances by one each time `h_pos` wraps, and returns to 0 after line `v_total`-1. The first pixel shown after a mode is taken up is position (0,0).
- R6: `hsync_n` is 0 exactly when `h_pos` is at or below `h_sync_end`, and 1 otherwise. `vsync_n` follows the same rule against `v_pos` and `v_sync_end`.
- R7: An axis is in its active range when its position is above its blank end and at or below its blank start. `hblank` and `vblank` are 1 outside the active range of their axis. `de` is 1 only when both axes are in their active range.
- R8: `depth_24` is 1 (24-bit 4:4:4) when `bpp` is greater than 18, and 0 (18-bit 4:4:4) when `bpp` is 18 or less.
- R9: The mode inputs are taken up only after the last pixel of a frame, at position (`h_total`-1, `v_total`-1). Changes made in mid-frame leave all outputs unchanged until then. While no usable mode is held, inputs are taken up on every cycle.
- R10: A mode with a zero sync length or a zero active length on either axis drives `mode_ok` to 0. One cycle later, and for as long as `mode_ok` stays 0, the outputs are idle: `h_pos`=`v_pos`=0, `hsync_n`=`vsync_n`=1, `hblank`=`vblank`=1 and `de`=0.
- R11: While `rst` is high, `mode_ok` is 0, every derived output is 0, and the raster outputs are idle as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| h_sync_len | input | FW | Horizontal sync length in pixels |
| h_back_porch | input | FW | Horizontal back porch in pixels |
| h_active | input | FW | Horizontal active length in pixels |
| h_front_porch | input | FW | Horizontal front porch in pixels |
| v_sync_len | input | FW | Vertical sync length in lines |
| v_back_porch | input | FW | Vertical back porch in lines |
| v_active | input | FW | Vertical active length in lines |
| v_front_porch | input | FW | Vertical front porch in lines |
| bpp | input | BPP_W | Bits per pixel of the mode |
| mode_ok | output | 1 | The held mode is usable |
| depth_24 | output | 1 | Pixel-depth select: 1 for 24-bit, 0 for 18-bit |
| h_total | output | FW+2 | Horizontal total |
| h_sync_end | output | FW+2 | Horizontal sync end position |
| h_blank_end | output | FW+2 | Horizontal blank end position |
| h_blank_start | output | FW+2 | Horizontal blank start position |
| v_total | output | FW+2 | Vertical total |
| v_sync_end | output | FW+2 | Vertical sync end position |
| v_blank_end | output | FW+2 | Vertical blank end position |
| v_blank_start | output | FW+2 | Vertical blank start position |
| h_pos | output | FW+2 | Horizontal position of the current raster output |
| v_pos | output | FW+2 | Vertical position of the current raster output |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| de | output | 1 | Data enable, inside the active window |

## Verification
On every cycle the assertions check the following. The derived values are ordered as the chain implies. The horizontal position steps by one except where it wraps to zero. Sync is asserted at the start of every line and frame. The data-enable window never overlaps either sync pulse. An unusable mode leaves the outputs idle. What the properties cannot show is whether the totals and edges hold the exact sums, where each edge falls on the sweep, what the depth select is for a given bits-per-pixel, and whether a mode change is held off until the last pixel of a frame. The bench shows these by sweeping whole frames of several modes: zero porches, minimum sync, maximum field values and unusable modes. It compares every output on every pixel against values computed from the mode arithmetic.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Pixel-depth select carried with the held mode.
  typedef enum logic {
    DEPTH_18_444 = 1'b0,
    DEPTH_24_444 = 1'b1
  } depth_e;

  // Largest bits-per-pixel value that still selects the 18-bit depth.
  localparam int DEPTH_SPLIT_BPP = 18;

endpackage

// File: rtl/raster_mode_calc.sv
module raster_mode_calc #(
  parameter int FW = 12,
  parameter int CW = FW + 2
) (
  input  logic [FW-1:0] sync_len,
  input  logic [FW-1:0] back_porch,
  input  logic [FW-1:0] active_len,
  input  logic [FW-1:0] front_porch,
  output logic [CW-1:0] total,
  output logic [CW-1:0] sync_end,
  output logic [CW-1:0] blank_end,
  output logic [CW-1:0] blank_start,
  output logic          usable
);

  // Each edge is built on the one before it, so the positions stay zero-based.
  always_comb begin
    total       = CW'(sync_len) + CW'(back_porch) + CW'(active_len) + CW'(front_porch);
    sync_end    = CW'(sync_len) - CW'(1);
    blank_end   = sync_end + CW'(back_porch);
    blank_start = blank_end + CW'(active_len);
    usable      = (sync_len != '0) && (active_len != '0);
  end

endmodule

// File: rtl/raster_axis_counter.sv
module raster_axis_counter #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          adv,
  input  logic [CW-1:0] last,
  output logic [CW-1:0] pos,
  output logic          wrap
);

  assign wrap = adv && (pos == last);

  always_ff @(posedge clk) begin
    if (clr) begin
      pos <= '0;
    end else if (adv) begin
      pos <= wrap ? '0 : pos + CW'(1);
    end
  end

endmodule

// File: rtl/raster_axis_decode.sv
module raster_axis_decode #(
  parameter int CW = 14
) (
  input  logic [CW-1:0] pos,
  input  logic [CW-1:0] sync_end,
  input  logic [CW-1:0] blank_end,
  input  logic [CW-1:0] blank_start,
  output logic          sync_on,
  output logic          act_on
);

  always_comb begin
    sync_on = (pos <= sync_end);
    act_on  = (pos > blank_end) && (pos <= blank_start);
  end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int FW    = 12,
  parameter int BPP_W = 6,
  localparam int CW   = FW + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FW-1:0]    h_sync_len,
  input  logic [FW-1:0]    h_back_porch,
  input  logic [FW-1:0]    h_active,
  input  logic [FW-1:0]    h_front_porch,
  input  logic [FW-1:0]    v_sync_len,
  input  logic [FW-1:0]    v_back_porch,
  input  logic [FW-1:0]    v_active,
  input  logic [FW-1:0]    v_front_porch,
  input  logic [BPP_W-1:0] bpp,
  output logic             mode_ok,
  output logic             depth_24,
  output logic [CW-1:0]    h_total,
  output logic [CW-1:0]    h_sync_end,
  output logic [CW-1:0]    h_blank_end,
  output logic [CW-1:0]    h_blank_start,
  output logic [CW-1:0]    v_total,
  output logic [CW-1:0]    v_sync_end,
  output logic [CW-1:0]    v_blank_end,
  output logic [CW-1:0]    v_blank_start,
  output logic [CW-1:0]    h_pos,
  output logic [CW-1:0]    v_pos,
  output logic             hsync_n,
  output logic             vsync_n,
  output logic             hblank,
  output logic             vblank,
  output logic             de
);

  localparam int AXES = 2;  // index 0 horizontal, index 1 vertical

  logic [AXES-1:0][FW-1:0] in_sync, in_back, in_act, in_front;
  logic [AXES-1:0][CW-1:0] nx_total, nx_se, nx_be, nx_bs;
  logic [AXES-1:0]         nx_use;

  logic [AXES-1:0][CW-1:0] m_total, m_se, m_be, m_bs, m_last;
  logic                    m_ok;
  depth_e                  m_depth;

  logic [AXES-1:0][CW-1:0] cnt_pos;
  logic [AXES-1:0]         cnt_adv, cnt_wrap;
  logic [AXES-1:0]         ax_sync, ax_act;
  logic                    cnt_clr, frame_end, load;

  assign in_sync  = {v_sync_len,    h_sync_len};
  assign in_back  = {v_back_porch,  h_back_porch};
  assign in_act   = {v_active,      h_active};
  assign in_front = {v_front_porch, h_front_porch};

  // Vertical advances on the horizontal wrap; horizontal advances every cycle.
  assign cnt_adv = {cnt_wrap[0], 1'b1};

  generate
    for (genvar a = 0; a < AXES; a++) begin : g_axis
      raster_mode_calc #(.FW(FW), .CW(CW)) u_calc (
        .sync_len    (in_sync[a]),
        .back_porch  (in_back[a]),
        .active_len  (in_act[a]),
        .front_porch (in_front[a]),
        .total       (nx_total[a]),
        .sync_end    (nx_se[a]),
        .blank_end   (nx_be[a]),
        .blank_start (nx_bs[a]),
        .usable      (nx_use[a])
      );

      assign m_last[a] = m_total[a] - CW'(1);

      raster_axis_counter #(.CW(CW)) u_cnt (
        .clk  (clk),
        .clr  (cnt_clr),
        .adv  (cnt_adv[a]),
        .last (m_last[a]),
        .pos  (cnt_pos[a]),
        .wrap (cnt_wrap[a])
      );

      raster_axis_decode #(.CW(CW)) u_dec (
        .pos         (cnt_pos[a]),
        .sync_end    (m_se[a]),
        .blank_end   (m_be[a]),
        .blank_start (m_bs[a]),
        .sync_on     (ax_sync[a]),
        .act_on      (ax_act[a])
      );
    end
  endgenerate

  assign cnt_clr   = rst || !m_ok;
  assign frame_end = m_ok && cnt_wrap[1];
  assign load      = !m_ok || frame_end;

  // Shadow of the mode: derived values taken up only at a frame boundary.
  always_ff @(posedge clk) begin
    if (rst) begin
      m_total <= '0;
      m_se    <= '0;
      m_be    <= '0;
      m_bs    <= '0;
      m_ok    <= 1'b0;
      m_depth <= DEPTH_18_444;
    end else if (load) begin
      m_total <= nx_total;
      m_se    <= nx_se;
      m_be    <= nx_be;
      m_bs    <= nx_bs;
      m_ok    <= &nx_use;
      m_depth <= (bpp > BPP_W'(DEPTH_SPLIT_BPP)) ? DEPTH_24_444 : DEPTH_18_444;
    end
  end

  // Registered raster outputs.
  always_ff @(posedge clk) begin
    if (rst || !m_ok) begin
      h_pos   <= '0;
      v_pos   <= '0;
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      hblank  <= 1'b1;
      vblank  <= 1'b1;
      de      <= 1'b0;
    end else begin
      h_pos   <= cnt_pos[0];
      v_pos   <= cnt_pos[1];
      hsync_n <= !ax_sync[0];
      vsync_n <= !ax_sync[1];
      hblank  <= !ax_act[0];
      vblank  <= !ax_act[1];
      de      <= &ax_act;
    end
  end

  assign mode_ok       = m_ok;
  assign depth_24      = (m_depth == DEPTH_24_444);
  assign h_total       = m_total[0];
  assign h_sync_end    = m_se[0];
  assign h_blank_end   = m_be[0];
  assign h_blank_start = m_bs[0];
  assign v_total       = m_total[1];
  assign v_sync_end    = m_se[1];
  assign v_blank_end   = m_be[1];
  assign v_blank_start = m_bs[1];

endmodule

// File: rtl/raster_timing_gen_chk.sv
module raster_timing_gen_chk #(
  parameter int FW    = 12,
  parameter int BPP_W = 6,
  localparam int CW   = FW + 2
) (
  input logic          clk,
  input logic          rst,
  input logic          mode_ok,
  input logic [CW-1:0] h_total,
  input logic [CW-1:0] h_sync_end,
  input logic [CW-1:0] h_blank_end,
  input logic [CW-1:0] h_blank_start,
  input logic [CW-1:0] v_total,
  input logic [CW-1:0] v_sync_end,
  input logic [CW-1:0] v_blank_end,
  input logic [CW-1:0] v_blank_start,
  input logic [CW-1:0] h_pos,
  input logic [CW-1:0] v_pos,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic          de
);

  // R3 and R4: the held edges of a usable mode are ordered inside the total.
  assert_h_blank_order_R4: assert property (@(posedge clk) disable iff (rst)
    mode_ok |-> (h_sync_end <= h_blank_end) && (h_blank_end < h_blank_start) &&
                (h_blank_start < h_total));

  assert_v_blank_order_R3: assert property (@(posedge clk) disable iff (rst)
    mode_ok |-> (v_sync_end <= v_blank_end) && (v_blank_end < v_blank_start) &&
                (v_blank_start < v_total));

  // R5: the horizontal position steps by one unless it returns to zero.
  assert_h_step_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_ok) && (h_pos != '0)) |-> (h_pos == CW'($past(h_pos) + CW'(1))));

  // R6: sync is asserted at the start of every line and every frame.
  assert_hsync_line_start_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_ok) && (h_pos == '0)) |-> !hsync_n);

  assert_vsync_frame_start_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_ok) && (v_pos == '0)) |-> !vsync_n);

  // R7: the data-enable window never overlaps a sync pulse.
  assert_de_clear_of_sync_R7: assert property (@(posedge clk) disable iff (rst)
    de |-> (hsync_n && vsync_n));

  // R10: an unusable mode leaves the raster outputs idle on the next cycle.
  assert_idle_when_unusable_R10: assert property (@(posedge clk) disable iff (rst)
    !mode_ok |=> (!de && hsync_n && vsync_n && (h_pos == '0) && (v_pos == '0)));

endmodule

bind raster_timing_gen raster_timing_gen_chk #(.FW(FW), .BPP_W(BPP_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mode_ok       (mode_ok),
  .h_total       (h_total),
  .h_sync_end    (h_sync_end),
  .h_blank_end   (h_blank_end),
  .h_blank_start (h_blank_start),
  .v_total       (v_total),
  .v_sync_end    (v_sync_end),
  .v_blank_end   (v_blank_end),
  .v_blank_start (v_blank_start),
  .h_pos         (h_pos),
  .v_pos         (v_pos),
  .hsync_n       (hsync_n),
  .vsync_n       (vsync_n),
  .de            (de)
);

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;

  localparam int BFW = 8;
  localparam int BBW = 6;
  localparam int BCW = BFW + 2;

  typedef struct {
    int hs, hb, ha, hf;
    int vs, vb, va, vf;
    int bpp;
  } mode_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [BFW-1:0] h_sync_len = '0, h_back_porch = '0, h_active = '0, h_front_porch = '0;
  logic [BFW-1:0] v_sync_len = '0, v_back_porch = '0, v_active = '0, v_front_porch = '0;
  logic [BBW-1:0] bpp = '0;
  logic           mode_ok, depth_24;
  logic [BCW-1:0] h_total, h_sync_end, h_blank_end, h_blank_start;
  logic [BCW-1:0] v_total, v_sync_end, v_blank_end, v_blank_start;
  logic [BCW-1:0] h_pos, v_pos;
  logic           hsync_n, vsync_n, hblank, vblank, de;

  int n_vec  = 0;
  int n_fail = 0;

  mode_t cur, nxt;
  bit    cur_ok  = 0;
  bit    nxt_ok  = 0;
  bit    pending = 0;
  int    exp_h   = 0;
  int    exp_v   = 0;

  always #4 clk = ~clk;

  raster_timing_gen #(.FW(BFW), .BPP_W(BBW)) u_raster_timing_gen (
    .clk, .rst,
    .h_sync_len, .h_back_porch, .h_active, .h_front_porch,
    .v_sync_len, .v_back_porch, .v_active, .v_front_porch,
    .bpp, .mode_ok, .depth_24,
    .h_total, .h_sync_end, .h_blank_end, .h_blank_start,
    .v_total, .v_sync_end, .v_blank_end, .v_blank_start,
    .h_pos, .v_pos, .hsync_n, .vsync_n, .hblank, .vblank, .de
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int f_tot(input int s, input int b, input int a, input int f);
    return s + b + a + f;
  endfunction

  function automatic bit usable(input mode_t m);
    return (m.hs != 0) && (m.ha != 0) && (m.vs != 0) && (m.va != 0);
  endfunction

  function automatic bit derived_match(input mode_t m);
    return (int'(h_total) == f_tot(m.hs, m.hb, m.ha, m.hf)) &&
           (int'(h_sync_end) == m.hs - 1) &&
           (int'(h_blank_end) == m.hs - 1 + m.hb) &&
           (int'(h_blank_start) == m.hs - 1 + m.hb + m.ha) &&
           (int'(v_total) == f_tot(m.vs, m.vb, m.va, m.vf)) &&
           (int'(v_sync_end) == m.vs - 1) &&
           (int'(v_blank_end) == m.vs - 1 + m.vb) &&
           (int'(v_blank_start) == m.vs - 1 + m.vb + m.va);
  endfunction

  task automatic drive(input mode_t m);
    h_sync_len    = BFW'(m.hs);
    h_back_porch  = BFW'(m.hb);
    h_active      = BFW'(m.ha);
    h_front_porch = BFW'(m.hf);
    v_sync_len    = BFW'(m.vs);
    v_back_porch  = BFW'(m.vb);
    v_active      = BFW'(m.va);
    v_front_porch = BFW'(m.vf);
    bpp           = BBW'(m.bpp);
  endtask

  task automatic check_idle(input string req);
    check(h_pos == '0,  req, "idle h_pos", int'(h_pos), 0);
    check(v_pos == '0,  req, "idle v_pos", int'(v_pos), 0);
    check(hsync_n,      req, "idle hsync_n", int'(hsync_n), 1);
    check(vsync_n,      req, "idle vsync_n", int'(vsync_n), 1);
    check(hblank && vblank, req, "idle blanks", int'({hblank, vblank}), 3);
    check(!de,          req, "idle de", int'(de), 0);
  endtask

  // One output sample, compared against the bench's own model of the sweep.
  task automatic step();
    bit sw;
    int htot, vtot, hse, hbe, hbs, vse, vbe, vbs;
    bit hact, vact;
    @(negedge clk);
    sw = 0;
    if (pending) sw = nxt_ok ? (mode_ok && derived_match(nxt)) : !mode_ok;
    if (cur_ok) begin
      htot = f_tot(cur.hs, cur.hb, cur.ha, cur.hf);
      vtot = f_tot(cur.vs, cur.vb, cur.va, cur.vf);
      hse = cur.hs - 1; hbe = hse + cur.hb; hbs = hbe + cur.ha;
      vse = cur.vs - 1; vbe = vse + cur.vb; vbs = vbe + cur.va;
      hact = (exp_h > hbe) && (exp_h <= hbs);
      vact = (exp_v > vbe) && (exp_v <= vbs);
      check(int'(h_pos) == exp_h, "R5", "h_pos", int'(h_pos), exp_h);
      check(int'(v_pos) == exp_v, "R5", "v_pos", int'(v_pos), exp_v);
      check(hsync_n == !(exp_h <= hse), "R6", "hsync_n", int'(hsync_n), int'(!(exp_h <= hse)));
      check(vsync_n == !(exp_v <= vse), "R6", "vsync_n", int'(vsync_n), int'(!(exp_v <= vse)));
      check(hblank == !hact, "R7", "hblank", int'(hblank), int'(!hact));
      check(vblank == !vact, "R7", "vblank", int'(vblank), int'(!vact));
      check(de == (hact && vact), "R7", "de", int'(de), int'(hact && vact));
      if (sw) begin
        // R9: the new mode appears only behind the last pixel of the frame.
        check((exp_h == htot - 1) && (exp_v == vtot - 1), "R9", "take-up position h*1000+v",
              exp_h * 1000 + exp_v, (htot - 1) * 1000 + (vtot - 1));
      end else begin
        check(mode_ok, "R10", "mode_ok", int'(mode_ok), 1);
        check(int'(h_total) == htot, "R1", "h_total", int'(h_total), htot);
        check(int'(v_total) == vtot, "R1", "v_total", int'(v_total), vtot);
        check(int'(h_sync_end) == hse, "R2", "h_sync_end", int'(h_sync_end), hse);
        check(int'(v_sync_end) == vse, "R2", "v_sync_end", int'(v_sync_end), vse);
        check(int'(h_blank_end) == hbe, "R3", "h_blank_end", int'(h_blank_end), hbe);
        check(int'(v_blank_end) == vbe, "R3", "v_blank_end", int'(v_blank_end), vbe);
        check(int'(h_blank_start) == hbs, "R4", "h_blank_start", int'(h_blank_start), hbs);
        check(int'(v_blank_start) == vbs, "R4", "v_blank_start", int'(v_blank_start), vbs);
        check(depth_24 == (cur.bpp > 18), "R8", "depth_24", int'(depth_24), int'(cur.bpp > 18));
      end
    end else begin
      check_idle("R10");
    end
    if (sw) begin
      cur = nxt; cur_ok = nxt_ok; pending = 0; exp_h = 0; exp_v = 0;
    end else if (cur_ok) begin
      htot = f_tot(cur.hs, cur.hb, cur.ha, cur.hf);
      vtot = f_tot(cur.vs, cur.vb, cur.va, cur.vf);
      exp_h++;
      if (exp_h == htot) begin
        exp_h = 0;
        exp_v++;
        if (exp_v == vtot) exp_v = 0;
      end
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic apply_and_wait(input mode_t m);
    int guard;
    drive(m);
    nxt = m; nxt_ok = usable(m); pending = 1;
    guard = 0;
    while (pending) begin
      step();
      guard++;
      if (guard > 20000) begin
        check(0, "R9", "mode take-up timeout cycles", guard, 0);
        pending = 0;
      end
    end
  endtask

  function automatic int frame_len(input mode_t m);
    return f_tot(m.hs, m.hb, m.ha, m.hf) * f_tot(m.vs, m.vb, m.va, m.vf);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_vec++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin : stimulus
    mode_t ma, mc, mb, mbig, mbad_h, mbad_v, mf;
    ma     = '{hs:3, hb:2, ha:8, hf:1, vs:2, vb:1, va:5, vf:2, bpp:24};
    mc     = '{hs:4, hb:5, ha:10, hf:3, vs:3, vb:2, va:6, vf:1, bpp:19};
    mb     = '{hs:1, hb:0, ha:6, hf:0, vs:1, vb:0, va:3, vf:0, bpp:18};
    mbig   = '{hs:255, hb:255, ha:255, hf:255, vs:1, vb:0, va:1, vf:0, bpp:0};
    mbad_h = '{hs:2, hb:1, ha:0, hf:1, vs:1, vb:1, va:2, vf:1, bpp:24};
    mbad_v = '{hs:2, hb:1, ha:3, hf:1, vs:0, vb:1, va:2, vf:1, bpp:24};
    mf     = '{hs:2, hb:3, ha:4, hf:5, vs:1, vb:2, va:2, vf:3, bpp:8};

    // R11: reset state.
    repeat (3) @(negedge clk);
    check(!mode_ok, "R11", "mode_ok in reset", int'(mode_ok), 0);
    check(h_total == '0 && v_total == '0, "R11", "totals in reset", int'(h_total), 0);
    check(h_blank_start == '0 && v_sync_end == '0, "R11", "edges in reset", int'(h_blank_start), 0);
    check_idle("R11");
    rst = 1'b0;
    run(3);

    // R1..R8 on a plain mode, then a mid-frame change held off (R9).
    apply_and_wait(ma);
    run(2 * frame_len(ma) + frame_len(ma) / 2);
    apply_and_wait(mc);
    run(2 * frame_len(mc));

    // Zero porches, one-cycle sync, bpp at the depth split.
    apply_and_wait(mb);
    run(2 * frame_len(mb));

    // Widest fields: the total needs the two extra bits.
    apply_and_wait(mbig);
    run(frame_len(mbig));

    // R10: zero active length, then zero sync length while already unusable.
    apply_and_wait(mbad_h);
    run(20);
    drive(mbad_v);
    cur = mbad_v;
    run(20);

    // Recovery from an unusable mode takes effect without waiting for a frame.
    apply_and_wait(mf);
    run(2 * frame_len(mf));

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule